// File: doc/BRIEF.md
# Interrupt Entry and Reset Sequencer

This block performs the control-transfer part of reset and interrupt handling for a small 8-bit processor whose stack lives in page one of a 16-bit address space. The instruction executor keeps the registers. At each instruction boundary it presents its program counter, its status byte and its stack pointer, and it pulses a strobe. The sequencer watches a non-maskable request latch, a reset request latch and a level-sensitive vector of maskable sources. It decides whether an entry is due. If one is, it takes over the memory port: it pushes the return state, fetches the handler address from the vector area, and hands back a single update word. That word carries the new counter, status and stack pointer, the cycle count to charge, and a jam-clear indication.

The memory port is a valid/ready request channel. The sequencer raises `mem_valid` with address, direction and write data, and holds all of them unchanged until `mem_ready` is high at a clock edge. Read data on `mem_rdata` is taken in that same handshake cycle, so the memory side returns the data combinationally with `mem_ready`. The sequencer never withdraws a request. The memory side may stall for any number of cycles. While `busy` is high the executor must stall, and boundary strobes are ignored. A request pulse (`nmi_pulse`, `rst_req`) is latched on the clock edge where it is seen. It can be acted on from the next cycle onward.

Top module: `irq_entry_seq`

## Requirements
- R1: After hardware reset, and on a reset request, the block reads 0xFFFC then 0xFFFD, writes nothing, and reports PC = {byte at 0xFFFD, byte at 0xFFFC}, status 0x04, stack pointer equal to `s_in` as sampled at acceptance, cycle count 0, kind code 0 and `upd_jam_clr` = 1.
- R2: A pending reset is accepted in the first idle cycle, with no boundary strobe needed. It is accepted even while jammed, and ahead of any pending NMI or IRQ. A pending NMI survives the reset and is taken at a later boundary.
- R3: An NMI or IRQ entry performs three writes to 0x0100 + S, then S-1, then S-2 (8-bit wrap). The data are PC high, then PC low, then the captured status with bit 4 forced to 0 and bit 5 forced to 1. The reported stack pointer is S-3, modulo 256.
- R4: NMI entry reads 0xFFFA then 0xFFFB, and IRQ entry reads 0xFFFE then 0xFFFF, low byte first. The reported status is the captured status with bit 2 set, the cycle count is 7, and the kind code is 1 for NMI and 2 for IRQ.
- R5: When NMI and IRQ are both pending at a boundary, the NMI is taken. Its pending state is cleared on acceptance, so one pulse yields exactly one entry.
- R6: An NMI pulse that arrives while an entry is in progress stays pending. It is taken at the first boundary after that entry, and not before.
- R7: An IRQ is taken only if bit 2 of the status presented at the previous accepted boundary was 0. After any entry or reset, the next boundary treats that bit as 1.
- R8: An IRQ is pending while any bit of `irq_lines` is high at the boundary. The lines are not latched, so lines that drop before the boundary cause no entry.
- R9: While `jammed` is high no NMI or IRQ entry starts. A pending NMI is kept and is taken at the first boundary after `jammed` falls.
- R10: `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` stay stable until a handshake. The sequence advances only on a handshake. `busy` is high from the cycle after acceptance until the update cycle inclusive.
- R11: `upd_valid` is high for exactly one cycle per accepted entry or reset, with all update fields valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; leaves a reset sequence pending |
| irq_lines | input | N_IRQ | Level maskable request sources, one bit each |
| nmi_pulse | input | 1 | One-cycle non-maskable request |
| rst_req | input | 1 | One-cycle request to run the reset sequence |
| boundary | input | 1 | Instruction-boundary strobe from the executor |
| jammed | input | 1 | Executor is jammed |
| pc_in | input | 16 | Program counter at the boundary |
| p_in | input | 8 | Status byte at the boundary (bit 2 = interrupt disable) |
| s_in | input | 8 | Stack pointer at the boundary |
| busy | output | 1 | Sequence in progress; executor must stall |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Request address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_ready |
| upd_valid | output | 1 | Update fields valid (one cycle) |
| upd_kind | output | 2 | 0 reset, 1 NMI, 2 IRQ |
| upd_pc | output | 16 | New program counter |
| upd_p | output | 8 | New status byte |
| upd_s | output | 8 | New stack pointer |
| upd_cycles | output | 4 | Cycles to charge for the entry |
| upd_jam_clr | output | 1 | Executor must clear its jammed state |

## Verification
A wrong priority, mask or pending latch shows up at the end of the next accepted boundary. It appears either as a `busy`/`mem_valid` rise where none is due, or as a missing rise, one clock after the strobe. A corrupted stack pointer or captured byte shows in the address or data of the very next push handshake. A wrong vector or wrong status merging shows only in the single `upd_valid` cycle, five to a few dozen cycles later depending on stalls. The bench compares every port against a behavioural model on every clock, so each of these faults is caught in the first cycle it becomes visible.

// File: rtl/ies_pkg.sv
package ies_pkg;

  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;

  localparam int FLAG_I = 2;
  localparam int FLAG_B = 4;
  localparam int FLAG_U = 5;

  localparam logic [ADDR_W-1:0] VEC_NMI_LO = 16'hFFFA;
  localparam logic [ADDR_W-1:0] VEC_RST_LO = 16'hFFFC;
  localparam logic [ADDR_W-1:0] VEC_IRQ_LO = 16'hFFFE;

  typedef enum logic [1:0] {
    EK_RESET = 2'd0,
    EK_NMI   = 2'd1,
    EK_IRQ   = 2'd2
  } entry_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_PUSH_ST,
    ST_VEC_LO,
    ST_VEC_HI,
    ST_DONE
  } seq_state_e;

endpackage

// File: rtl/ies_vec_sel.sv
module ies_vec_sel
  import ies_pkg::*;
(
  input  entry_kind_e        kind_i,
  input  logic               hi_i,
  output logic [ADDR_W-1:0]  addr_o
);

  logic [ADDR_W-1:0] base;

  always_comb begin
    unique case (kind_i)
      EK_RESET: base = VEC_RST_LO;
      EK_NMI:   base = VEC_NMI_LO;
      default:  base = VEC_IRQ_LO;
    endcase
    addr_o = {base[ADDR_W-1:1], hi_i};
  end

endmodule

// File: rtl/ies_arbiter.sv
module ies_arbiter
  import ies_pkg::*;
#(
  parameter int N_IRQ = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_lines,
  input  logic             nmi_pulse,
  input  logic             rst_req,
  input  logic             boundary,
  input  logic             jammed,
  input  logic             i_flag,
  input  logic             fsm_idle_i,
  output logic             start_o,
  output entry_kind_e      kind_o
);

  logic rst_pend_q;
  logic nmi_pend_q;
  logic i_prev_q;
  logic irq_any;
  logic take_rst;
  logic take_nmi;
  logic take_irq;

  always_comb begin
    irq_any  = |irq_lines;
    take_rst = fsm_idle_i && rst_pend_q;
    take_nmi = fsm_idle_i && !rst_pend_q && boundary && nmi_pend_q && !jammed;
    take_irq = fsm_idle_i && !rst_pend_q && boundary && !nmi_pend_q &&
               irq_any && !i_prev_q && !jammed;
    start_o  = take_rst || take_nmi || take_irq;
    if (take_rst)      kind_o = EK_RESET;
    else if (take_nmi) kind_o = EK_NMI;
    else               kind_o = EK_IRQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pend_q <= 1'b1;
      nmi_pend_q <= 1'b0;
      i_prev_q   <= 1'b1;
    end else begin
      if (take_rst) rst_pend_q <= rst_req;
      else          rst_pend_q <= rst_pend_q | rst_req;

      if (take_nmi) nmi_pend_q <= nmi_pulse;
      else          nmi_pend_q <= nmi_pend_q | nmi_pulse;

      if (start_o)                      i_prev_q <= 1'b1;
      else if (fsm_idle_i && boundary)  i_prev_q <= i_flag;
    end
  end

  // R2: a pending reset wins the first idle cycle
  p_reset_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_pend_q && fsm_idle_i) |-> (start_o && kind_o == EK_RESET));

  // R6: a pending NMI is only dropped by its own acceptance
  p_nmi_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend_q && !(start_o && kind_o == EK_NMI)) |=> nmi_pend_q);

  // R7: after any acceptance the next boundary sees the mask as set
  p_mask_after_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> i_prev_q);

endmodule

// File: rtl/ies_entry_fsm.sv
module ies_entry_fsm
  import ies_pkg::*;
#(
  parameter int          CYC_W        = 4,
  parameter int          ENTRY_CYCLES = 7,
  parameter logic [7:0]  STACK_PAGE   = 8'h01
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  entry_kind_e        kind_i,
  input  logic [ADDR_W-1:0]  pc_in,
  input  logic [BYTE_W-1:0]  p_in,
  input  logic [BYTE_W-1:0]  s_in,
  output logic               idle_o,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [BYTE_W-1:0]  mem_wdata,
  input  logic [BYTE_W-1:0]  mem_rdata,
  output logic               upd_valid,
  output entry_kind_e        upd_kind,
  output logic [ADDR_W-1:0]  upd_pc,
  output logic [BYTE_W-1:0]  upd_p,
  output logic [BYTE_W-1:0]  upd_s,
  output logic [CYC_W-1:0]   upd_cycles,
  output logic               upd_jam_clr
);

  seq_state_e        state_q;
  logic [ADDR_W-1:0] pc_q;
  logic [BYTE_W-1:0] p_q;
  logic [BYTE_W-1:0] s_q;
  logic [ADDR_W-1:0] npc_q;
  entry_kind_e       kind_q;
  logic              hs;
  logic              pushing;
  logic [BYTE_W-1:0] st_byte;
  logic [ADDR_W-1:0] vec_addr;

  ies_vec_sel u_vec (
    .kind_i (kind_q),
    .hi_i   (state_q == ST_VEC_HI),
    .addr_o (vec_addr)
  );

  always_comb begin
    st_byte         = p_q;
    st_byte[FLAG_B] = 1'b0;
    st_byte[FLAG_U] = 1'b1;

    pushing   = (state_q == ST_PUSH_HI) || (state_q == ST_PUSH_LO) ||
                (state_q == ST_PUSH_ST);
    mem_valid = pushing || (state_q == ST_VEC_LO) || (state_q == ST_VEC_HI);
    mem_we    = pushing;
    mem_addr  = pushing ? {STACK_PAGE, s_q} : vec_addr;
    unique case (state_q)
      ST_PUSH_HI: mem_wdata = pc_q[15:8];
      ST_PUSH_LO: mem_wdata = pc_q[7:0];
      ST_PUSH_ST: mem_wdata = st_byte;
      default:    mem_wdata = '0;
    endcase
    hs     = mem_valid && mem_ready;
    idle_o = (state_q == ST_IDLE);

    upd_valid   = (state_q == ST_DONE);
    upd_kind    = kind_q;
    upd_pc      = npc_q;
    upd_s       = s_q;
    upd_jam_clr = (kind_q == EK_RESET);
    if (kind_q == EK_RESET) begin
      upd_p      = BYTE_W'(1) << FLAG_I;
      upd_cycles = '0;
    end else begin
      upd_p         = p_q;
      upd_p[FLAG_I] = 1'b1;
      upd_cycles    = CYC_W'(ENTRY_CYCLES);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      p_q     <= '0;
      s_q     <= '0;
      npc_q   <= '0;
      kind_q  <= EK_RESET;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          pc_q    <= pc_in;
          p_q     <= p_in;
          s_q     <= s_in;
          kind_q  <= kind_i;
          state_q <= (kind_i == EK_RESET) ? ST_VEC_LO : ST_PUSH_HI;
        end
        ST_PUSH_HI: if (hs) begin
          s_q     <= s_q - 8'd1;
          state_q <= ST_PUSH_LO;
        end
        ST_PUSH_LO: if (hs) begin
          s_q     <= s_q - 8'd1;
          state_q <= ST_PUSH_ST;
        end
        ST_PUSH_ST: if (hs) begin
          s_q     <= s_q - 8'd1;
          state_q <= ST_VEC_LO;
        end
        ST_VEC_LO: if (hs) begin
          npc_q[7:0] <= mem_rdata;
          state_q    <= ST_VEC_HI;
        end
        ST_VEC_HI: if (hs) begin
          npc_q[15:8] <= mem_rdata;
          state_q     <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R10: a stalled request is held unchanged
  p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R3: each accepted push moves the stack pointer down by one
  p_sp_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_we) |=> (s_q == $past(s_q) - 8'd1));

  // R4: every read falls in the vector area
  p_vec_region_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_we) |-> (mem_addr[15:3] == 13'h1FFF));

  // R11: the update strobe lasts one cycle
  p_upd_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> !upd_valid);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import ies_pkg::*;
#(
  parameter int N_IRQ        = 4,
  parameter int CYC_W        = 4,
  parameter int ENTRY_CYCLES = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_lines,
  input  logic             nmi_pulse,
  input  logic             rst_req,
  input  logic             boundary,
  input  logic             jammed,
  input  logic [15:0]      pc_in,
  input  logic [7:0]       p_in,
  input  logic [7:0]       s_in,
  output logic             busy,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_we,
  output logic [15:0]      mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic [7:0]       mem_rdata,
  output logic             upd_valid,
  output logic [1:0]       upd_kind,
  output logic [15:0]      upd_pc,
  output logic [7:0]       upd_p,
  output logic [7:0]       upd_s,
  output logic [CYC_W-1:0] upd_cycles,
  output logic             upd_jam_clr
);

  logic        fsm_idle;
  logic        start;
  entry_kind_e start_kind;
  entry_kind_e upd_kind_e;

  ies_arbiter #(.N_IRQ(N_IRQ)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_lines  (irq_lines),
    .nmi_pulse  (nmi_pulse),
    .rst_req    (rst_req),
    .boundary   (boundary),
    .jammed     (jammed),
    .i_flag     (p_in[FLAG_I]),
    .fsm_idle_i (fsm_idle),
    .start_o    (start),
    .kind_o     (start_kind)
  );

  ies_entry_fsm #(.CYC_W(CYC_W), .ENTRY_CYCLES(ENTRY_CYCLES)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .kind_i      (start_kind),
    .pc_in       (pc_in),
    .p_in        (p_in),
    .s_in        (s_in),
    .idle_o      (fsm_idle),
    .mem_valid   (mem_valid),
    .mem_ready   (mem_ready),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .upd_valid   (upd_valid),
    .upd_kind    (upd_kind_e),
    .upd_pc      (upd_pc),
    .upd_p       (upd_p),
    .upd_s       (upd_s),
    .upd_cycles  (upd_cycles),
    .upd_jam_clr (upd_jam_clr)
  );

  assign busy     = !fsm_idle;
  assign upd_kind = upd_kind_e;

  // R9: no interrupt push starts while jammed
  p_no_push_jammed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_idle && jammed) |=> !(mem_valid && mem_we));

endmodule

// File: tb/irq_entry_seq_tb_top.sv
`timescale 1ns/100ps
module irq_entry_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  irq_lines = '0;
  logic        nmi_pulse = 1'b0;
  logic        rst_req = 1'b0;
  logic        boundary = 1'b0;
  logic        jammed = 1'b0;
  logic [15:0] pc_in = 16'h1234;
  logic [7:0]  p_in = 8'h13;
  logic [7:0]  s_in = 8'hFD;
  logic        busy, mem_valid, mem_we, upd_valid, upd_jam_clr;
  logic        mem_ready = 1'b1;
  logic [15:0] mem_addr, upd_pc;
  logic [7:0]  mem_wdata, mem_rdata, upd_p, upd_s;
  logic [1:0]  upd_kind;
  logic [3:0]  upd_cycles;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  bit ready_stall = 1'b0;
  int tick = 0;
  logic [23:0] wq[$];

  always #2.5 clk = ~clk;

  assign mem_rdata = mem_addr[7:0] ^ 8'hA5;

  irq_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .nmi_pulse(nmi_pulse),
    .rst_req(rst_req), .boundary(boundary), .jammed(jammed), .pc_in(pc_in),
    .p_in(p_in), .s_in(s_in), .busy(busy), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .upd_valid(upd_valid),
    .upd_kind(upd_kind), .upd_pc(upd_pc), .upd_p(upd_p), .upd_s(upd_s),
    .upd_cycles(upd_cycles), .upd_jam_clr(upd_jam_clr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural reference: phase 0 idle, 1..3 pushes, 4..5 vector reads, 6 update
  int m_ph, m_kind;
  bit m_rstp, m_nmip, m_iprev;
  logic [15:0] m_pc, m_npc;
  logic [7:0]  m_p, m_s;

  function automatic logic [15:0] m_vec(int kind);
    if (kind == 0) return 16'hFFFC;
    if (kind == 1) return 16'hFFFA;
    return 16'hFFFE;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_rstp = 1; m_nmip = 0; m_iprev = 1; m_kind = 0;
      m_pc = 0; m_npc = 0; m_p = 0; m_s = 0;
    end else if (m_ph == 0) begin
      bit tr, tn, ti;
      tr = m_rstp;
      tn = !m_rstp && boundary && m_nmip && !jammed;
      ti = !m_rstp && boundary && !m_nmip && (irq_lines != 0) && !m_iprev && !jammed;
      if (tr || tn || ti) begin
        m_kind = tr ? 0 : (tn ? 1 : 2);
        m_pc = pc_in; m_p = p_in; m_s = s_in;
        m_ph = tr ? 4 : 1;
        m_iprev = 1;
      end else if (boundary) m_iprev = p_in[2];
      m_rstp = tr ? rst_req : (m_rstp | rst_req);
      m_nmip = tn ? nmi_pulse : (m_nmip | nmi_pulse);
    end else begin
      m_rstp = m_rstp | rst_req;
      m_nmip = m_nmip | nmi_pulse;
      if (m_ph == 6) m_ph = 0;
      else if (mem_ready) begin
        if (m_ph <= 3) m_s = m_s - 8'd1;
        if (m_ph == 4) m_npc[7:0] = m_vec(m_kind) ^ 8'hA5;
        if (m_ph == 5) m_npc[15:8] = (m_vec(m_kind) + 16'd1) ^ 8'hA5;
        m_ph = m_ph + 1;
      end
    end
    if (rst_n && mem_valid && mem_ready && mem_we) wq.push_back({mem_addr, mem_wdata});
  end

  always @(negedge clk) begin
    tick++;
    mem_ready <= !(ready_stall && (tick % 3 == 1));
    if (rst_n) begin
      bit ev;
      ev = (m_ph >= 1 && m_ph <= 5);
      chk(mem_valid == ev, "R10", "mem_valid", mem_valid, ev);
      chk(busy == (m_ph != 0), "R10", "busy", busy, m_ph != 0);
      if (ev && mem_valid) begin
        logic [15:0] ea;
        logic [7:0] ed;
        ea = (m_ph <= 3) ? {8'h01, m_s} : (m_vec(m_kind) + ((m_ph == 5) ? 16'd1 : 16'd0));
        chk(mem_addr == ea, m_ph <= 3 ? "R3" : "R4", "mem_addr", mem_addr, ea);
        chk(mem_we == (m_ph <= 3), "R3", "mem_we", mem_we, m_ph <= 3);
        if (m_ph <= 3) begin
          ed = (m_ph == 1) ? m_pc[15:8] : (m_ph == 2) ? m_pc[7:0] : ((m_p & 8'hEF) | 8'h20);
          chk(mem_wdata == ed, "R3", "mem_wdata", mem_wdata, ed);
        end
      end
      chk(upd_valid == (m_ph == 6), "R11", "upd_valid", upd_valid, m_ph == 6);
      if (m_ph == 6 && upd_valid) begin
        chk(upd_kind == 2'(m_kind), "R4", "upd_kind", upd_kind, m_kind);
        chk(upd_pc == m_npc, "R4", "upd_pc", upd_pc, m_npc);
        chk(upd_p == ((m_kind == 0) ? 8'h04 : (m_p | 8'h04)), "R4", "upd_p", upd_p, m_p);
        chk(upd_s == m_s, "R3", "upd_s", upd_s, m_s);
        chk(upd_cycles == ((m_kind == 0) ? 4'd0 : 4'd7), "R1", "upd_cycles", upd_cycles, m_kind);
        chk(upd_jam_clr == (m_kind == 0), "R1", "upd_jam_clr", upd_jam_clr, m_kind == 0);
      end
    end
  end

  task automatic edge_sync();
    @(negedge clk); #1;
  endtask

  task automatic pulse_boundary();
    edge_sync(); boundary = 1'b1;
    edge_sync(); boundary = 1'b0;
  endtask

  task automatic pulse_nmi();
    edge_sync(); nmi_pulse = 1'b1;
    edge_sync(); nmi_pulse = 1'b0;
  endtask

  task automatic expect_quiet(input int n, input string req);
    repeat (n) begin
      @(negedge clk);
      chk(!busy && !upd_valid, req, "no entry expected, busy", busy, 0);
    end
    #1;
  endtask

  task automatic expect_upd(input int kind, input logic [15:0] pc, input logic [7:0] p,
                            input logic [7:0] s, input int cyc, input bit jc, input string req);
    bit seen;
    seen = 0;
    for (int i = 0; i < 80 && !seen; i++) begin
      @(negedge clk);
      if (upd_valid) seen = 1;
    end
    chk(seen, req, "update seen", seen, 1);
    if (seen) begin
      chk(upd_kind == 2'(kind), req, "kind", upd_kind, kind);
      chk(upd_pc == pc, req, "pc", upd_pc, pc);
      chk(upd_p == p, req, "status", upd_p, p);
      chk(upd_s == s, req, "stack", upd_s, s);
      chk(upd_cycles == 4'(cyc), req, "cycles", upd_cycles, cyc);
      chk(upd_jam_clr == jc, req, "jam_clr", upd_jam_clr, jc);
    end
    #1;
  endtask

  task automatic expect_writes(input logic [23:0] a, input logic [23:0] b,
                               input logic [23:0] c, input string req);
    chk(wq.size() == 3, req, "push count", wq.size(), 3);
    if (wq.size() == 3) begin
      chk(wq[0] == a, req, "first push", wq[0], a);
      chk(wq[1] == b, req, "second push", wq[1], b);
      chk(wq[2] == c, req, "third push", wq[2], c);
    end
  endtask

  initial begin
    // R1: quiet while held in reset, then the power-up reset sequence
    repeat (2) @(negedge clk);
    chk(!mem_valid && !upd_valid && !busy, "R1", "outputs in reset", mem_valid, 0);
    #1 rst_n = 1'b1;
    expect_upd(0, 16'h5859, 8'h04, 8'hFD, 0, 1, "R1");
    chk(wq.size() == 0, "R1", "reset writes", wq.size(), 0);

    // R7: first boundary after reset is masked; the next one takes the IRQ
    irq_lines = 4'b0001;
    pulse_boundary();
    expect_quiet(6, "R7");
    wq.delete();
    pulse_boundary();
    expect_upd(2, 16'h5A5B, 8'h17, 8'hFA, 7, 0, "R4");
    expect_writes({16'h01FD, 8'h12}, {16'h01FC, 8'h34}, {16'h01FB, 8'h23}, "R3");
    irq_lines = '0;

    // R5: NMI beats IRQ, and is taken once
    pulse_boundary();
    pulse_nmi();
    irq_lines = 4'b1000;
    pulse_boundary();
    expect_upd(1, 16'h5E5F, 8'h17, 8'hFA, 7, 0, "R5");
    pulse_boundary();
    expect_quiet(6, "R5");
    // R8: a single high line among several is enough
    pulse_boundary();
    expect_upd(2, 16'h5A5B, 8'h17, 8'hFA, 7, 0, "R8");

    // R6: NMI during an IRQ entry waits for the next boundary
    pulse_boundary();
    pulse_boundary();
    pulse_nmi();
    expect_upd(2, 16'h5A5B, 8'h17, 8'hFA, 7, 0, "R6");
    irq_lines = '0;
    expect_quiet(4, "R6");
    pulse_boundary();
    expect_upd(1, 16'h5E5F, 8'h17, 8'hFA, 7, 0, "R6");

    // R8: lines that drop before the boundary leave nothing behind
    pulse_boundary();
    irq_lines = 4'b0110;
    edge_sync();
    irq_lines = '0;
    pulse_boundary();
    expect_quiet(6, "R8");

    // R9: jammed blocks entry; NMI kept until the jam ends
    jammed = 1'b1;
    pulse_nmi();
    pulse_boundary();
    expect_quiet(6, "R9");
    jammed = 1'b0;
    pulse_boundary();
    expect_upd(1, 16'h5E5F, 8'h17, 8'hFA, 7, 0, "R9");

    // R2: reset beats pending NMI and IRQ, needs no boundary, ignores jam
    pulse_boundary();
    jammed = 1'b1;
    irq_lines = 4'b0001;
    pulse_nmi();
    edge_sync(); rst_req = 1'b1;
    edge_sync(); rst_req = 1'b0;
    expect_upd(0, 16'h5859, 8'h04, 8'hFD, 0, 1, "R2");
    jammed = 1'b0;
    irq_lines = '0;
    pulse_boundary();
    expect_upd(1, 16'h5E5F, 8'h17, 8'hFA, 7, 0, "R2");

    // R10 with stalls, R3 with stack pointer wrap
    ready_stall = 1'b1;
    s_in = 8'h01;
    pc_in = 16'hBEEF;
    pulse_nmi();
    wq.delete();
    pulse_boundary();
    expect_upd(1, 16'h5E5F, 8'h17, 8'hFE, 7, 0, "R3");
    expect_writes({16'h0101, 8'hBE}, {16'h0100, 8'hEF}, {16'h01FF, 8'h23}, "R3");
    ready_stall = 1'b0;
    expect_quiet(3, "R10");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule